// File: doc/BRIEF.md
# Product Term Cluster Allocator

This block is the steering fabric for one logic block of sixteen macrocells. The product-term AND array supplies sixteen clusters. Each cluster has four basic product terms and one extra term. The allocator sums the terms of each cluster. It then routes each cluster to one macrocell within a short, non-wrapping neighbourhood. For each macrocell it ORs together the clusters that arrive there and passes the result through an XOR stage. The second input of that XOR is either the cluster's extra term or a programmed polarity constant.

Configuration inputs are static for a given use of the block. One bit per macrocell sets its mode (synchronous or asynchronous). The mode fixes how many basic terms the home cluster of that macrocell carries. One bit per cluster decides whether the extra term joins the cluster or goes to the XOR. One bit per macrocell holds the polarity constant. A 16x16 selection matrix says which clusters each macrocell takes. The block has no clock and no registers. A legality check rejects selections that fall outside the reachable window and clusters that are claimed twice. A rejected cluster contributes nothing to any macrocell.

Top module: `ptca_allocator`

## Requirements
- R1: A cluster whose home macrocell is synchronous (home_async bit = 0) sums all four of its basic terms. Cluster c owns pt_terms bits 4c to 4c+3.
- R2: A cluster whose home macrocell is asynchronous (home_async bit = 1) sums only its basic terms at bits 4c and 4c+1. Its terms at bits 4c+2 and 4c+3 have no effect on any output.
- R3: The width of a cluster is set by the mode of its home macrocell, which is the macrocell with the same index. This holds even when the cluster is steered to a different macrocell.
- R4: When extra_join[c] = 1, extra term c is ORed into cluster c. The second XOR input of macrocell c is then xor_const[c].
- R5: When extra_join[c] = 0, extra term c is the second XOR input of macrocell c. It is not part of the cluster sum.
- R6: Macrocell m may take cluster c only when m-1 <= c <= m+2, within 0..15, with no wrapping. steer_sel bit 16m+c requests cluster c for macrocell m. Any request outside that window marks cluster c as faulty, and the cluster then contributes 0.
- R7: A cluster requested by more than one macrocell is faulty and contributes 0 to every macrocell.
- R8: A macrocell that receives no cluster has 0 as its first XOR input. If its home cluster is steered away, the output follows its extra term alone when extra_join is 0.
- R9: Each macrocell output equals the OR of all clusters legally granted to it, XORed with the selected second input. Up to four extended clusters of five terms each can reach one macrocell.
- R10: cluster_fault[c] is high exactly for faulty clusters. config_error is high when any cluster is faulty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pt_terms | input | 64 | Basic product terms, four per cluster, cluster c at bits 4c..4c+3 |
| extra_terms | input | 16 | Extra product term of each cluster |
| home_async | input | 16 | Mode of each macrocell: 1 asynchronous, 0 synchronous |
| extra_join | input | 16 | 1: extra term joins its cluster; 0: extra term drives the home XOR |
| xor_const | input | 16 | Polarity constant used as second XOR input when the extra term joins |
| steer_sel | input | 256 | Bit 16m+c: macrocell m requests cluster c |
| mc_out | output | 16 | Per-macrocell XOR stage result |
| cluster_fault | output | 16 | Cluster c rejected by the legality check |
| config_error | output | 1 | Any cluster rejected |

## Verification
The hardest situation to reach is a steered cluster whose width comes from a home macrocell in a different mode than its destination. Here only a term in the upper half of the cluster tells the two widths apart. The bench builds this case directly: it mixes modes on adjacent macrocells and places a single active term in each lane in turn. A second hard case is a double claim combined with window edges at macrocells 0 and 15. For these, a sweep drives sparse random selection matrices, some limited to the window and some not. The bench compares every output against an arithmetic model that counts owners per cluster.

// File: rtl/ptca_pkg.sv
package ptca_pkg;

  // Reach of a macrocell relative to its own index: clusters m-BELOW .. m+ABOVE.
  localparam int unsigned REACH_BELOW = 1;
  localparam int unsigned REACH_ABOVE = 2;

  // True when macrocell m may legally take cluster c.
  function automatic logic may_take(int m, int c, int below, int above);
    return (c >= m - below) && (c <= m + above);
  endfunction

  // Number of live basic lanes in a cluster given its home mode.
  function automatic int lane_count(logic home_async, int sync_n, int async_n);
    return home_async ? async_n : sync_n;
  endfunction

endpackage

// File: rtl/ptca_cluster_sum.sv
module ptca_cluster_sum #(
  parameter int N_CL     = 16,
  parameter int PT_SYNC  = 4,
  parameter int PT_ASYNC = 2
) (
  input  logic [N_CL*PT_SYNC-1:0] pt_i,
  input  logic [N_CL-1:0]         xt_i,
  input  logic [N_CL-1:0]         async_i,
  input  logic [N_CL-1:0]         join_i,
  output logic [N_CL-1:0]         sum_o
);

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    logic [PT_SYNC-1:0] live;
    int                 width;

    always_comb begin
      width = ptca_pkg::lane_count(async_i[c], PT_SYNC, PT_ASYNC);
      for (int i = 0; i < PT_SYNC; i++)
        live[i] = pt_i[c*PT_SYNC+i] && (i < width);
    end

    assign sum_o[c] = (|live) | (join_i[c] & xt_i[c]);

    always_comb begin
      if (async_i[c] && !join_i[c] && (pt_i[c*PT_SYNC +: PT_ASYNC] == '0))
        AST_ASYNC_NARROW: assert (!sum_o[c]); // R2
      if (join_i[c] && xt_i[c])
        AST_EXTRA_JOINS: assert (sum_o[c]); // R4
    end
  end

endmodule

// File: rtl/ptca_steer_check.sv
module ptca_steer_check #(
  parameter int N     = 16,
  parameter int BELOW = 1,
  parameter int ABOVE = 2
) (
  input  logic [N*N-1:0] sel_i,
  output logic [N-1:0]   bad_o,
  output logic [N*N-1:0] grant_o,
  output logic           err_o
);

  logic [N-1:0] stray;
  logic [N-1:0] shared;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      int owners;
      owners   = 0;
      stray[c] = 1'b0;
      for (int m = 0; m < N; m++) begin
        if (sel_i[m*N+c]) begin
          owners = owners + 1;
          if (!ptca_pkg::may_take(m, c, BELOW, ABOVE)) stray[c] = 1'b1;
        end
      end
      shared[c] = (owners > 1);
    end
  end

  assign bad_o = stray | shared;
  assign err_o = |bad_o;

  always_comb begin
    for (int m = 0; m < N; m++)
      for (int c = 0; c < N; c++)
        grant_o[m*N+c] = sel_i[m*N+c] & ~bad_o[c];
  end

  // Every granted cluster has a single owner inside its window.
  always_comb begin
    for (int c = 0; c < N; c++) begin
      logic [N-1:0] col;
      for (int m = 0; m < N; m++) col[m] = grant_o[m*N+c];
      AST_ONE_OWNER: assert ($countones(col) <= 1); // R7
      for (int m = 0; m < N; m++)
        if (col[m])
          AST_IN_WINDOW: assert (ptca_pkg::may_take(m, c, BELOW, ABOVE)); // R6
    end
  end

endmodule

// File: rtl/ptca_mc_xor.sv
module ptca_mc_xor #(
  parameter int N = 16
) (
  input  logic [N*N-1:0] grant_i,
  input  logic [N-1:0]   sum_i,
  input  logic [N-1:0]   xt_i,
  input  logic [N-1:0]   join_i,
  input  logic [N-1:0]   pol_i,
  output logic [N-1:0]   first_o,
  output logic [N-1:0]   mc_o
);

  for (genvar m = 0; m < N; m++) begin : g_mc
    logic second;
    assign first_o[m] = |(grant_i[m*N +: N] & sum_i);
    assign second     = join_i[m] ? pol_i[m] : xt_i[m];
    assign mc_o[m]    = first_o[m] ^ second;
  end

endmodule

// File: rtl/ptca_allocator.sv
module ptca_allocator #(
  parameter int N_MC     = 16,
  parameter int PT_SYNC  = 4,
  parameter int PT_ASYNC = 2
) (
  input  logic [N_MC*PT_SYNC-1:0] pt_terms,
  input  logic [N_MC-1:0]         extra_terms,
  input  logic [N_MC-1:0]         home_async,
  input  logic [N_MC-1:0]         extra_join,
  input  logic [N_MC-1:0]         xor_const,
  input  logic [N_MC*N_MC-1:0]    steer_sel,
  output logic [N_MC-1:0]         mc_out,
  output logic [N_MC-1:0]         cluster_fault,
  output logic                    config_error
);

  localparam int BELOW = ptca_pkg::REACH_BELOW;
  localparam int ABOVE = ptca_pkg::REACH_ABOVE;

  logic [N_MC-1:0]      cl_sum;
  logic [N_MC*N_MC-1:0] grant;
  logic [N_MC-1:0]      first_in;

  ptca_cluster_sum #(.N_CL(N_MC), .PT_SYNC(PT_SYNC), .PT_ASYNC(PT_ASYNC)) u_sum (
    .pt_i   (pt_terms),
    .xt_i   (extra_terms),
    .async_i(home_async),
    .join_i (extra_join),
    .sum_o  (cl_sum)
  );

  ptca_steer_check #(.N(N_MC), .BELOW(BELOW), .ABOVE(ABOVE)) u_chk (
    .sel_i  (steer_sel),
    .bad_o  (cluster_fault),
    .grant_o(grant),
    .err_o  (config_error)
  );

  ptca_mc_xor #(.N(N_MC)) u_xor (
    .grant_i(grant),
    .sum_i  (cl_sum),
    .xt_i   (extra_terms),
    .join_i (extra_join),
    .pol_i  (xor_const),
    .first_o(first_in),
    .mc_o   (mc_out)
  );

  // Port-level guards.
  always_comb begin
    for (int m = 0; m < N_MC; m++) begin
      if (grant[m*N_MC +: N_MC] == '0 && !extra_join[m])
        AST_EMPTY_PASSES_EXTRA: assert (mc_out[m] == extra_terms[m]); // R8
      if (!config_error)
        for (int c = 0; c < N_MC; c++)
          if (steer_sel[m*N_MC+c])
            AST_CLEAN_MEANS_LEGAL: assert (ptca_pkg::may_take(m, c, BELOW, ABOVE)); // R10
    end
  end

endmodule

// File: tb/ptca_allocator_tb.sv
module ptca_allocator_tb;
  localparam int N = 16;
  localparam int P = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N*P-1:0] pt;
  logic [N-1:0]   xt, amode, ext, pol;
  logic [N*N-1:0] sel;
  logic [N-1:0]   out_w, bad_w;
  logic           err_w;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  ptca_allocator u_dut (
    .pt_terms(pt), .extra_terms(xt), .home_async(amode), .extra_join(ext),
    .xor_const(pol), .steer_sel(sel),
    .mc_out(out_w), .cluster_fault(bad_w), .config_error(err_w)
  );

  task automatic clear();
    pt = '0; xt = '0; amode = '0; ext = '0; pol = '0; sel = '0;
  endtask

  task automatic take(int m, int c);
    sel[m*N+c] = 1'b1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic chkv(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Independent model: count owners, test reach, sum lanes, then XOR.
  task automatic model(output logic [N-1:0] eo, output logic [N-1:0] eb, output logic ee);
    logic [N-1:0] s;
    for (int c = 0; c < N; c++) begin
      int cnt = 0;
      bit far = 0;
      int w = amode[c] ? 2 : 4;
      for (int m = 0; m < N; m++)
        if (sel[m*N+c]) begin
          cnt++;
          if (c < m - 1 || c > m + 2) far = 1;
        end
      eb[c] = (cnt > 1) || far;
      s[c] = ext[c] & xt[c];
      for (int i = 0; i < w; i++) if (pt[c*P+i]) s[c] = 1'b1;
    end
    ee = (eb != 0);
    for (int m = 0; m < N; m++) begin
      logic f = 1'b0;
      for (int c = 0; c < N; c++) if (sel[m*N+c] && !eb[c] && s[c]) f = 1'b1;
      eo[m] = f ^ (ext[m] ? pol[m] : xt[m]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] eo, eb;
    logic ee;
    clear();
    settle();
    chkv("idle out", out_w, '0);
    chkv("idle fault", bad_w, '0);
    chk1("idle err", err_w, 1'b0);

    // R1: every synchronous lane reaches its home macrocell
    for (int c = 0; c < N; c++)
      for (int i = 0; i < 4; i++) begin
        clear(); take(c, c); pt[c*P+i] = 1'b1; settle();
        chkv("R1 sync lane", out_w, 16'(1) << c);
      end

    // R2: asynchronous home keeps only two lanes
    for (int c = 0; c < N; c++)
      for (int i = 0; i < 4; i++) begin
        clear(); amode = '1; take(c, c); pt[c*P+i] = 1'b1; settle();
        chkv("R2 async lane", out_w, (i < 2) ? (16'(1) << c) : 16'(0));
      end

    // R3: steered cluster keeps its home width
    for (int i = 0; i < 4; i++) begin
      clear(); amode[4] = 1'b1; take(5, 4); pt[4*P+i] = 1'b1; settle();
      chk1("R3 async home to sync dest", out_w[5], i < 2);
      clear(); amode[5] = 1'b1; take(5, 4); pt[4*P+i] = 1'b1; settle();
      chk1("R3 sync home to async dest", out_w[5], 1'b1);
    end

    // R4: extra term joins, constant drives XOR
    clear(); take(6, 6); ext[6] = 1; xt[6] = 1; settle();
    chk1("R4 joined extra pol0", out_w[6], 1'b1);
    pol[6] = 1; settle();
    chk1("R4 joined extra pol1", out_w[6], 1'b0);
    xt[6] = 0; settle();
    chk1("R4 empty cluster pol1", out_w[6], 1'b1);

    // R5: extra term on XOR
    clear(); take(6, 6); xt[6] = 1; pol[6] = 1; settle();
    chk1("R5 extra alone", out_w[6], 1'b1);
    pt[6*P] = 1; settle();
    chk1("R5 sum xor extra", out_w[6], 1'b0);

    // R8: home cluster steered away
    clear(); take(8, 7); xt[7] = 1; pt[7*P] = 1; settle();
    chkv("R8 steered away, extra alone", out_w, 16'h0180);
    ext[7] = 1; xt[7] = 1; pt[7*P] = 0; settle();
    chkv("R8 extra travels with cluster", out_w, 16'h0100);
    clear(); xt = 16'hA5A5; settle();
    chkv("R8 no clusters", out_w, 16'hA5A5);

    // R6: window edges
    clear(); take(0, 3); pt[3*P] = 1; settle();
    chkv("R6 m0 c3 out", out_w, '0);
    chkv("R6 m0 c3 fault", bad_w, 16'h0008);
    chk1("R6 m0 c3 err", err_w, 1'b1);
    clear(); take(15, 13); pt[13*P] = 1; settle();
    chkv("R6 m15 c13 fault", bad_w, 16'h2000);
    chkv("R6 m15 c13 out", out_w, '0);
    clear(); take(5, 3); pt[3*P] = 1; settle();
    chkv("R6 m5 c3 fault", bad_w, 16'h0008);
    clear(); take(0, 2); pt[2*P] = 1; settle();
    chkv("R6 m0 c2 legal", out_w, 16'h0001);
    chk1("R6 m0 c2 err", err_w, 1'b0);
    clear(); take(15, 14); pt[14*P+3] = 1; settle();
    chkv("R6 m15 c14 legal", out_w, 16'h8000);

    // R7: double claim
    clear(); take(4, 5); take(5, 5); pt[5*P] = 1; settle();
    chkv("R7 double out", out_w, '0);
    chkv("R7 double fault", bad_w, 16'h0020);
    chk1("R7 double err", err_w, 1'b1);

    // R9: twenty-term sum on macrocell 5
    for (int t = 0; t < 20; t++) begin
      clear(); ext = '1;
      for (int c = 4; c < 8; c++) take(5, c);
      if (t < 16) pt[4*P+t] = 1'b1; else xt[4+t-16] = 1'b1;
      settle();
      chkv("R9 wide sum term", out_w, 16'h0020);
    end

    // R10: sparse random sweep, windowed and unrestricted
    for (int v = 0; v < 600; v++) begin
      pt = {$urandom, $urandom}; xt = 16'($urandom); amode = 16'($urandom);
      ext = 16'($urandom); pol = 16'($urandom); sel = '0;
      for (int m = 0; m < N; m++)
        for (int c = 0; c < N; c++)
          if (v % 2 == 0) begin
            if (c >= m - 1 && c <= m + 2 && ($urandom % 5 == 0)) sel[m*N+c] = 1'b1;
          end else if ($urandom % 20 == 0) sel[m*N+c] = 1'b1;
      settle();
      model(eo, eb, ee);
      chkv("R10 sweep out", out_w, eo);
      chkv("R10 sweep fault", bad_w, eb);
      chk1("R10 sweep err", err_w, ee);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule